// File: doc/BRIEF.md
# Sampled Entropy Collector

This register block collects raw random bits into an output buffer whose length software chooses. A 32-bit register bus reaches a control register, a sample-period register and a bank of eight 32-bit output words. A single raw entropy input stands in for a set of free-running oscillator rings. A two-bit speed code is driven back out to those rings. The entropy input is treated as synchronous to the block clock.

Software programs the sample period and sets the enable bit. It then raises the start bit with a masked write, so that the other control fields are left alone. While start is set, the block captures the entropy input once every sample period and shifts each captured bit into a buffer. When the selected number of bits has arrived, the selected output words are loaded together and start drops back to 0. Software watches for start to clear, then reads the words.

Top module: `entropy_gather`

## Requirements
- R1: After reset the control register, the period register and all eight output words read 0, and `osc_speed` is 0.
- R2: A write to the control register (offset 0x400) changes a lower-half bit i only when bit 16+i of the write data is 1; a write whose upper halfword is 0 changes nothing.
- R3: Control fields are: start at bit 0, enable at bit 1, ring speed at bits 3:2 (driven on `osc_speed`), and length select at bits 5:4 (0, 1, 2, 3 give 64, 128, 192, 256 bits). Bits 31:6 read as 0.
- R4: The period register at offset 0x404 reads back the 32-bit value written. While start is set with period P, one entropy bit is captured on every P-th rising edge counted from the edge that set start.
- R5: A period of 0 behaves as a period of 1, so a bit is captured on every edge.
- R6: For a length of N bits and an effective period P, start reads 1 up to the N·P-th edge after the edge that set it, and reads 0 from that edge on.
- R7: While enable is 0, a write setting start leaves start at 0, and no capture or output update happens.
- R8: Output word w is read at offset 0x410+4·w (w = 0..7) and holds buffer bits 32w+31..32w. The k-th captured bit of an N-bit run (k = 1..N) sits at buffer bit N−k, so the newest bit is bit 0 of word 0.
- R9: Output words keep their contents until a run completes. On completion, words 0..N/32−1 are loaded on the same edge and the higher words keep their previous contents.
- R10: A control write of 0 under a full 16-bit mask clears start and enable and ends a run in progress. The output words keep their previous contents.
- R11: If a control write lands on the edge where a run completes, start reads 0 afterwards, whatever value the write gives it. The other fields in the write still take effect.
- R12: Reads of any offset other than 0x400, 0x404 and the eight word offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; the upper half is the control write mask |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ent_bit | input | 1 | Raw entropy bit from the oscillator rings |
| osc_speed | output | 2 | Ring speed code from the control register |

## Verification
The completion of a run and a software write to the control register can fall on the same clock edge. Both of them want to decide the next value of the start bit. The bench provokes this with a 64-bit run at period 1, placing a masked write that sets start and a new ring speed exactly on the 64th edge. The result passes only if start reads 0 afterwards, the new speed reaches `osc_speed` and the output words still receive the completed run.

// File: rtl/eg_pkg.sv
package eg_pkg;

    localparam int unsigned BUS_W     = 32;
    localparam int unsigned HALF_W    = 16;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned LEN_STEP  = 64;
    localparam int unsigned LEN_CODES = 4;
    localparam int unsigned MAX_BITS  = LEN_STEP * LEN_CODES;
    localparam int unsigned WORDS     = MAX_BITS / BUS_W;
    localparam int unsigned CNT_W     = $clog2(MAX_BITS + 1);

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 12'h410;

    // Field order sets bit positions: start is bit 0, length select bits 5:4.
    typedef struct packed {
        logic [1:0] len_sel;
        logic [1:0] speed;
        logic       enable;
        logic       start;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef logic [WORDS-1:0][BUS_W-1:0] word_bank_t;

    function automatic int unsigned len_bits(input logic [1:0] sel);
        return LEN_STEP * (int'(sel) + 1);
    endfunction

    function automatic int unsigned len_words(input logic [1:0] sel);
        return len_bits(sel) / BUS_W;
    endfunction

    function automatic ctrl_t masked_merge(input ctrl_t old_v,
                                           input ctrl_t new_v,
                                           input ctrl_t mask_v);
        return ctrl_t'((old_v & ~mask_v) | (new_v & mask_v));
    endfunction

endpackage

// File: rtl/eg_ctrl_reg.sv
module eg_ctrl_reg
    import eg_pkg::*;
#(
    parameter int unsigned PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_ctrl,
    input  logic                wr_period,
    input  ctrl_t               wr_val,
    input  ctrl_t               wr_mask,
    input  logic [PERIOD_W-1:0] wr_period_val,
    input  logic                done,
    output ctrl_t               ctrl_q,
    output logic [PERIOD_W-1:0] period_q
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d = masked_merge(ctrl_q, wr_val, wr_mask);
        end
        if (!ctrl_d.enable) begin
            ctrl_d.start = 1'b0;
        end
        if (done) begin
            ctrl_d.start = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_period) begin
                period_q <= wr_period_val;
            end
        end
    end

endmodule

// File: rtl/eg_sampler.sv
module eg_sampler #(
    parameter int unsigned PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);

    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] last_cnt;

    always_comb begin
        if (period == '0) begin
            last_cnt = '0;
        end else begin
            last_cnt = period - 1'b1;
        end
        tick = active && (cnt_q >= last_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!active || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/eg_collector.sv
module eg_collector
    import eg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       tick,
    input  logic       ent_bit,
    input  logic [1:0] len_sel,
    output logic       done,
    output word_bank_t words_q
);

    logic [MAX_BITS-2:0] shift_q;
    logic [MAX_BITS-1:0] shift_next;
    logic [CNT_W-1:0]    got_q;
    logic [CNT_W-1:0]    last_idx;

    always_comb begin
        shift_next = {shift_q, ent_bit};
        last_idx   = CNT_W'(len_bits(len_sel) - 1);
        done       = tick && (got_q >= last_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            got_q   <= '0;
        end else if (!active || done) begin
            got_q <= '0;
        end else if (tick) begin
            shift_q <= shift_next[MAX_BITS-2:0];
            got_q   <= got_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
        end else if (done) begin
            for (int w = 0; w < int'(WORDS); w++) begin
                if (w < int'(len_words(len_sel))) begin
                    words_q[w] <= shift_next[w*BUS_W +: BUS_W];
                end
            end
        end
    end

endmodule

// File: rtl/entropy_gather.sv
module entropy_gather
    import eg_pkg::*;
#(
    parameter int unsigned PERIOD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ent_bit,
    output logic [1:0]        osc_speed
);

    logic                wr_ctrl;
    logic                wr_period;
    ctrl_t               ctrl_q;
    logic [PERIOD_W-1:0] period_q;
    logic                tick;
    logic                done;
    word_bank_t          words_q;
    logic [WORDS-1:0]    word_hit;

    assign wr_ctrl   = bus_sel && bus_we && (bus_addr == OFS_CTRL);
    assign wr_period = bus_sel && bus_we && (bus_addr == OFS_PERIOD);

    eg_ctrl_reg #(.PERIOD_W(PERIOD_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr_ctrl      (wr_ctrl),
        .wr_period    (wr_period),
        .wr_val       (ctrl_t'(bus_wdata[CTRL_W-1:0])),
        .wr_mask      (ctrl_t'(bus_wdata[HALF_W +: CTRL_W])),
        .wr_period_val(bus_wdata[PERIOD_W-1:0]),
        .done         (done),
        .ctrl_q       (ctrl_q),
        .period_q     (period_q)
    );

    eg_sampler #(.PERIOD_W(PERIOD_W)) u_samp (
        .clk   (clk),
        .rst   (rst),
        .active(ctrl_q.start),
        .period(period_q),
        .tick  (tick)
    );

    eg_collector u_coll (
        .clk    (clk),
        .rst    (rst),
        .active (ctrl_q.start),
        .tick   (tick),
        .ent_bit(ent_bit),
        .len_sel(ctrl_q.len_sel),
        .done   (done),
        .words_q(words_q)
    );

    for (genvar w = 0; w < int'(WORDS); w++) begin : g_hit
        assign word_hit[w] = (bus_addr == OFS_DATA + ADDR_W'(4 * w));
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL) begin
            bus_rdata = BUS_W'(ctrl_q);
        end else if (bus_addr == OFS_PERIOD) begin
            bus_rdata = BUS_W'(period_q);
        end else begin
            for (int w = 0; w < int'(WORDS); w++) begin
                if (word_hit[w]) begin
                    bus_rdata = words_q[w];
                end
            end
        end
    end

    assign osc_speed = ctrl_q.speed;

endmodule

// File: rtl/eg_checker.sv
module eg_checker
    import eg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input ctrl_t             ctrl_q,
    input logic              period_zero,
    input logic              tick,
    input logic              done,
    input logic              wr_ctrl,
    input logic [HALF_W-1:0] wmask,
    input word_bank_t        words_q
);

    assert_start_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.enable |-> !ctrl_q.start);

    assert_zero_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wmask == '0 && !done) |=> $stable(ctrl_q));

    assert_tick_only_running_R4: assert property (@(posedge clk) disable iff (rst)
        tick |-> ctrl_q.start);

    assert_zero_period_every_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.start && period_zero) |-> tick);

    assert_done_clears_start_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !ctrl_q.start);

    assert_words_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(words_q));

endmodule

bind entropy_gather eg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_q     (ctrl_q),
    .period_zero(period_q == '0),
    .tick       (tick),
    .done       (done),
    .wr_ctrl    (wr_ctrl),
    .wmask      (bus_wdata[31:16]),
    .words_q    (words_q)
);

// File: tb/entropy_gather_tb.sv
`timescale 1ns/1ps
module entropy_gather_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ent_bit = 1'b0;
    logic [1:0]  osc_speed;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] model [8];

    localparam logic [11:0] A_CTRL = 12'h400;
    localparam logic [11:0] A_PER  = 12'h404;
    localparam logic [11:0] A_DAT  = 12'h410;

    // Vector table: period, length code, seed, expected edges to completion.
    localparam int NV = 4;
    localparam int V_PER [NV] = '{1, 2, 0, 3};
    localparam int V_LEN [NV] = '{0, 3, 1, 2};
    localparam int V_SEED[NV] = '{32'h1234, 32'h0BEE, 32'h7A11, 32'h55C3};
    localparam int V_EDGE[NV] = '{64, 512, 128, 576};

    always #2.5 clk = ~clk;

    entropy_gather u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ent_bit(ent_bit), .osc_speed(osc_speed)
    );

    function automatic logic pat(input int seed, input int j);
        logic [31:0] x;
        x = (32'(j) * 32'h9E3779B1) ^ 32'(seed);
        return ^(x ^ (x >> 7));
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic check_words(input string req);
        logic [31:0] v;
        for (int w = 0; w < 8; w++) begin
            bus_rd(A_DAT + 12'(4 * w), v);
            chk(req, $sformatf("word %0d", w), v, model[w]);
        end
    endtask

    // Runs one collection; when clash is set a control write lands on the final edge.
    task automatic run_collect(input int per, input int lsel, input int seed,
                               input int edges, input bit clash,
                               input logic [31:0] clash_data);
        logic [255:0] buf_v;
        int peff, n;
        peff = (per == 0) ? 1 : per;
        n = 64 * (lsel + 1);
        bus_wr(A_PER, 32'(per));
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_CTRL;
        bus_wdata = {16'h003F, 16'(lsel << 4) | 16'h0003};
        for (int j = 1; j <= edges; j++) begin
            @(negedge clk);
            if (j == 1) begin bus_sel = 1'b0; bus_we = 1'b0; end
            ent_bit = pat(seed, j);
            if (j == edges) begin
                bus_addr = A_CTRL;
                #1 chk("R6", "start still set before last capture", {31'b0, bus_rdata[0]}, 32'd1);
                if (clash) begin
                    bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = clash_data;
                end
            end
        end
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_addr = A_CTRL;
        #1 chk("R6", "start cleared at completion edge", {31'b0, bus_rdata[0]}, 32'd0);
        buf_v = '0;
        for (int k = 1; k <= n; k++) buf_v[n - k] = pat(seed, k * peff);
        for (int w = 0; w < n / 32; w++) model[w] = buf_v[w*32 +: 32];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int w = 0; w < 8; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(A_CTRL, v); chk("R1", "ctrl after reset", v, 32'h0);
        bus_rd(A_PER, v);  chk("R1", "period after reset", v, 32'h0);
        chk("R1", "osc_speed after reset", 32'(osc_speed), 32'h0);
        check_words("R1");

        // R12 unmapped offsets
        bus_rd(12'h000, v); chk("R12", "offset 0x000", v, 0);
        bus_rd(12'h408, v); chk("R12", "offset 0x408", v, 0);
        bus_rd(12'h411, v); chk("R12", "offset 0x411", v, 0);
        bus_rd(12'h430, v); chk("R12", "offset 0x430", v, 0);
        bus_rd(12'hFFC, v); chk("R12", "offset 0xFFC", v, 0);

        // R3 field layout, upper bits read zero
        bus_wr(A_CTRL, 32'hFFFF_FFF6);
        bus_rd(A_CTRL, v); chk("R3", "ctrl fields", v, 32'h36);
        chk("R3", "osc_speed from bits 3:2", 32'(osc_speed), 32'd1);

        // R2 masked writes
        bus_wr(A_CTRL, 32'h000C_0008);
        bus_rd(A_CTRL, v); chk("R2", "speed-only mask", v, 32'h3A);
        chk("R2", "osc_speed follows", 32'(osc_speed), 32'd2);
        bus_wr(A_CTRL, 32'h0000_FFFF);
        bus_rd(A_CTRL, v); chk("R2", "zero mask changes nothing", v, 32'h3A);

        // R7 start ignored while disabled
        bus_wr(A_CTRL, 32'h0002_0000);
        bus_wr(A_CTRL, 32'h0001_0001);
        bus_rd(A_CTRL, v); chk("R7", "start stays 0 when disabled", v, 32'h38);
        repeat (300) @(negedge clk);
        check_words("R7");

        // R4 period register
        bus_wr(A_PER, 32'h1234_5678);
        bus_rd(A_PER, v); chk("R4", "period readback", v, 32'h1234_5678);

        // R4 R5 R6 R8 R9 vector walk
        for (int i = 0; i < NV; i++) begin
            run_collect(V_PER[i], V_LEN[i], V_SEED[i], V_EDGE[i], 1'b0, 32'h0);
            check_words((V_PER[i] == 0) ? "R5" : "R8");
        end

        // R10 stop in the middle of a run
        bus_wr(A_PER, 32'd3);
        bus_wr(A_CTRL, 32'h003F_0033);
        repeat (100) @(negedge clk);
        bus_wr(A_CTRL, 32'hFFFF_0000);
        bus_rd(A_CTRL, v); chk("R10", "ctrl after stop", v, 32'h0);
        chk("R10", "osc_speed after stop", 32'(osc_speed), 32'h0);
        repeat (900) @(negedge clk);
        check_words("R10");

        // R11 control write on the completion edge
        run_collect(1, 0, 32'h6D2B, 64, 1'b1, 32'h000D_000D);
        bus_rd(A_CTRL, v); chk("R11", "ctrl after clash", v, 32'h0E);
        chk("R11", "osc_speed after clash", 32'(osc_speed), 32'd3);
        check_words("R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule